// File: doc/BRIEF.md
# Edge Timetagger Message Generator

This block watches a small group of digital input lines that are already in the system clock domain. Each line passes through a glitch filter, and then an edge detector compares successive filtered levels. Every rising or falling edge that is enabled gets a 48-bit free-running cycle timestamp. The block turns it into a 64-bit message on a valid/ready stream. Software can also ask for a marker message by pulsing a request line. Whenever messages are lost, the stream carries a dedicated overflow message at the point of the loss.

Events that appear in one cycle are copied into a holding register, together with the timestamp and the filtered input snapshot of that cycle. A three-state controller then drains the holding register one message per cycle. In `S_IDLE` nothing is held and the stream is idle. In `S_EMIT` the lowest pending item is offered. In `S_OVFL` the overflow message is offered until the stream accepts it.

The transitions are as follows:
- IDLE→OVFL when a loss is recorded.
- IDLE→EMIT when items are captured and no loss is recorded.
- EMIT→OVFL when the offered item is refused.
- EMIT→EMIT while items remain.
- EMIT→IDLE or EMIT→OVFL once the holding register is empty, depending on whether a loss is recorded.
- OVFL→OVFL while the stream refuses the message.
- OVFL→EMIT or OVFL→IDLE once the message is accepted, depending on whether items remain.

The stream has no buffering. A message is offered for exactly one cycle, and a low ready in that cycle discards it. The only exception is the overflow message, which is held until it is accepted.

Top module: `tt_msg_gen`

## Requirements
- R1: A synchronous active-high reset clears the following:
  - the timestamp counter
  - the filter state, so all filtered levels read 0
  - the holding register
  - the loss flag
  
  `msg_valid` is low during reset and in the first cycle after it.
- R2: A filtered level takes a new input value only after that value has been sampled on 4 consecutive clock edges. A pulse or glitch lasting 3 cycles or less produces no message and leaves the filtered level unchanged.
- R3: Bit 2c of `edge_en` enables rising edges of channel c, and bit 2c+1 enables falling edges of channel c. An edge whose enable bit is 0 produces no message, but the filtered level still follows the input.
- R4: An event message holds the following fields; every other bit is 0:
  - bits 63:60 = 4'h2
  - bits 59:57 = channel index
  - bit 56 = 1 for a falling edge, 0 for a rising edge
  - bits 51:48 = filtered levels of all channels after the event, channel c in bit 48+c
  - bits 47:0 = timestamp
- R5: The timestamp counter reads 0 in the first cycle after reset, adds 1 every cycle and wraps modulo 2^48. An event's timestamp is the counter value of the first cycle in which the filtered level holds the new value. For an input change first driven in the cycle where the counter reads v, this timestamp is v+5.
- R6: Enabled edges seen in the same cycle become separate messages, one per accepted cycle. They are sent in ascending order of `edge_en` bit index, and all carry the same timestamp and level snapshot.
- R7: A one-cycle pulse on `mark_req` produces a marker message, regardless of `edge_en`. The marker has bits 63:56 = 8'h30, bits 51:48 = the filtered levels, bits 47:0 = the counter value of the pulse cycle, and zeros elsewhere. A marker captured together with events is sent after them, with the same timestamp.
- R8: A message offered while `msg_ready` is low is discarded. The overflow message is then offered, and held until it is accepted. The remaining held messages follow it.
- R9: Enabled edges or markers arriving while the holding register is not empty are discarded. An overflow message is then sent after the held messages have drained. The filtered levels still follow the inputs.
- R10: An overflow message is 64'h4000_0000_0000_0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tag_in | input | NCH (4) | Digital input lines, already synchronous to clk |
| edge_en | input | 2*NCH (8) | Per-channel rise (even bit) and fall (odd bit) enables |
| mark_req | input | 1 | One-cycle request for a marker message |
| msg_ready | input | 1 | Downstream can take a message this cycle |
| msg_valid | output | 1 | A message is offered this cycle |
| msg_data | output | 64 | Offered message |

## Verification
The assertions assume the following about the inputs:
- `tag_in` is synchronous to the clock.
- `mark_req` is a single-cycle pulse.
- `edge_en` changes only while nothing is pending.

The stimulus respects all three. It drives every input one time step after a rising edge and holds it for whole cycles. It raises the marker request for exactly one cycle. It changes the enable mask only between vectors, after the stream has gone quiet. Within those limits, the bench uses a deliberately low `msg_ready` and closely spaced edges to create both kinds of loss.

// File: rtl/tt_pkg.sv
package tt_pkg;

    localparam int MSG_W   = 64;
    localparam int TS_FLD  = 48;
    localparam int LVL_FLD = 4;

    localparam logic [3:0] CODE_EVENT  = 4'h2;
    localparam logic [7:0] CODE_MARKER = 8'h30;
    localparam logic [7:0] CODE_OVFL   = 8'h40;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_EMIT = 2'd1,
        S_OVFL = 2'd2
    } tt_state_t;

    function automatic logic [MSG_W-1:0] pack_event(
        input logic [2:0]         chan,
        input logic               is_fall,
        input logic [LVL_FLD-1:0] lvl,
        input logic [TS_FLD-1:0]  stamp
    );
        return {CODE_EVENT, chan, is_fall, 4'b0000, lvl, stamp};
    endfunction

    function automatic logic [MSG_W-1:0] pack_marker(
        input logic [LVL_FLD-1:0] lvl,
        input logic [TS_FLD-1:0]  stamp
    );
        return {CODE_MARKER, 4'b0000, lvl, stamp};
    endfunction

    function automatic logic [MSG_W-1:0] pack_ovfl();
        return {CODE_OVFL, 56'd0};
    endfunction

endpackage

// File: rtl/tt_glitch_filter.sv
module tt_glitch_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic level,
    output logic rise_pulse,
    output logic fall_pulse
);

    localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    logic          sampled;
    logic [CW-1:0] run_cnt;
    logic          settle;

    assign settle = (sampled != level) && (run_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            sampled    <= 1'b0;
            level      <= 1'b0;
            run_cnt    <= '0;
            rise_pulse <= 1'b0;
            fall_pulse <= 1'b0;
        end else begin
            sampled    <= raw_in;
            rise_pulse <= settle &&  sampled;
            fall_pulse <= settle && !sampled;
            if (sampled == level) begin
                run_cnt <= '0;
            end else if (settle) begin
                level   <= sampled;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // R2: a new level always comes from the sample seen on the previous edge
    a_r2_level_from_sample: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && level != $past(level)) |-> level == $past(sampled));

    // R2: a change of level is always flagged by exactly one edge pulse
    a_r2_pulse_on_change: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && level != $past(level)) |-> (rise_pulse ^ fall_pulse));

endmodule

// File: rtl/tt_timestamp.sv
module tt_timestamp #(
    parameter int TSW = 48
) (
    input  logic           clk,
    input  logic           rst,
    output logic [TSW-1:0] ts
);

    always_ff @(posedge clk) begin
        if (rst) ts <= '0;
        else     ts <= ts + 1'b1;
    end

    // R5: counter advances by one every cycle, wrapping at its width
    a_r5_ts_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ts == TSW'($past(ts) + 1'b1));

endmodule

// File: rtl/tt_serializer.sv
module tt_serializer
    import tt_pkg::*;
#(
    parameter int NCH = 4,
    parameter int TSW = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   rise_ev,
    input  logic [NCH-1:0]   fall_ev,
    input  logic [NCH-1:0]   level,
    input  logic [TSW-1:0]   ts,
    input  logic [2*NCH-1:0] edge_en,
    input  logic             mark_req,
    input  logic             msg_ready,
    output logic             msg_valid,
    output logic [MSG_W-1:0] msg_data
);

    localparam int NI  = 2 * NCH + 1;
    localparam int IW  = $clog2(NI);
    localparam int MKI = NI - 1;

    tt_state_t      state, state_n;
    logic [NI-1:0]  held, held_n;
    logic [NI-1:0]  incoming;
    logic [NI-1:0]  cur_bit;
    logic [IW-1:0]  cur_idx;
    logic [TSW-1:0] ts_h;
    logic [NCH-1:0] lvl_h;
    logic           loss, loss_n;
    logic           busy, capture;

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_hit
            assign incoming[2*c]   = rise_ev[c] & edge_en[2*c];
            assign incoming[2*c+1] = fall_ev[c] & edge_en[2*c+1];
        end
    endgenerate
    assign incoming[MKI] = mark_req;

    assign busy    = |held;
    assign capture = (|incoming) && !busy;
    assign cur_bit = held & (~held + 1'b1);

    always_comb begin
        cur_idx = '0;
        for (int i = NI - 1; i >= 0; i--) begin
            if (held[i]) cur_idx = IW'(i);
        end
    end

    // next holding contents and loss flag
    always_comb begin
        held_n = held;
        loss_n = loss;
        if (state == S_EMIT) begin
            held_n = held & ~cur_bit;
            if (!msg_ready) loss_n = 1'b1;
        end
        if (state == S_OVFL && msg_ready) loss_n = 1'b0;
        if (|incoming) begin
            if (!busy) held_n = incoming;
            else       loss_n = 1'b1;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE: begin
                if (loss)         state_n = S_OVFL;
                else if (|held_n) state_n = S_EMIT;
                else              state_n = S_IDLE;
            end
            S_EMIT: begin
                if (!msg_ready)   state_n = S_OVFL;
                else if (|held_n) state_n = S_EMIT;
                else if (loss_n)  state_n = S_OVFL;
                else              state_n = S_IDLE;
            end
            S_OVFL: begin
                if (!msg_ready)   state_n = S_OVFL;
                else if (|held_n) state_n = S_EMIT;
                else if (loss_n)  state_n = S_OVFL;
                else              state_n = S_IDLE;
            end
            default:              state_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            held  <= '0;
            loss  <= 1'b0;
            ts_h  <= '0;
            lvl_h <= '0;
        end else begin
            state <= state_n;
            held  <= held_n;
            loss  <= loss_n;
            if (capture) begin
                ts_h  <= ts;
                lvl_h <= level;
            end
        end
    end

    // outputs
    always_comb begin
        msg_valid = 1'b0;
        msg_data  = '0;
        unique case (state)
            S_IDLE: begin
                msg_valid = 1'b0;
            end
            S_EMIT: begin
                msg_valid = 1'b1;
                if (cur_idx == IW'(MKI))
                    msg_data = pack_marker(LVL_FLD'(lvl_h), TS_FLD'(ts_h));
                else
                    msg_data = pack_event(3'(cur_idx >> 1), cur_idx[0],
                                          LVL_FLD'(lvl_h), TS_FLD'(ts_h));
            end
            S_OVFL: begin
                msg_valid = 1'b1;
                msg_data  = pack_ovfl();
            end
            default: msg_valid = 1'b0;
        endcase
    end

    // R8: a refused overflow message stays on the stream unchanged
    a_r8_ovfl_held: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_data == pack_ovfl() && !msg_ready)
            |=> (msg_valid && msg_data == pack_ovfl()));

    // R8: a refused event or marker leads to an overflow message next cycle
    a_r8_drop_reports: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_data != pack_ovfl() && !msg_ready)
            |=> (msg_valid && msg_data == pack_ovfl()));

    // R9: requests arriving while items are held raise the loss flag
    a_r9_discard_flags: assert property (@(posedge clk) disable iff (rst)
        (busy && (|incoming)) |=> loss);

    // R6: the drain state only ever runs with something held
    a_r6_emit_has_item: assert property (@(posedge clk) disable iff (rst)
        (state == S_EMIT) |-> busy);

    // R6: each drained cycle removes exactly one held item
    a_r6_one_per_cycle: assert property (@(posedge clk) disable iff (rst)
        (state == S_EMIT && !(|incoming))
            |=> $countones(held) == $countones($past(held)) - 1);

endmodule

// File: rtl/tt_msg_gen.sv
module tt_msg_gen
    import tt_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int FILT_LEN = 4,
    parameter int TSW      = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   tag_in,
    input  logic [2*NCH-1:0] edge_en,
    input  logic             mark_req,
    input  logic             msg_ready,
    output logic             msg_valid,
    output logic [63:0]      msg_data
);

    logic [NCH-1:0] lvl;
    logic [NCH-1:0] rise_ev;
    logic [NCH-1:0] fall_ev;
    logic [TSW-1:0] ts;

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_chan
            tt_glitch_filter #(.FILT_LEN(FILT_LEN)) i_filt (
                .clk        (clk),
                .rst        (rst),
                .raw_in     (tag_in[c]),
                .level      (lvl[c]),
                .rise_pulse (rise_ev[c]),
                .fall_pulse (fall_ev[c])
            );
        end
    endgenerate

    tt_timestamp #(.TSW(TSW)) i_ts (
        .clk (clk),
        .rst (rst),
        .ts  (ts)
    );

    tt_serializer #(.NCH(NCH), .TSW(TSW)) i_ser (
        .clk       (clk),
        .rst       (rst),
        .rise_ev   (rise_ev),
        .fall_ev   (fall_ev),
        .level     (lvl),
        .ts        (ts),
        .edge_en   (edge_en),
        .mark_req  (mark_req),
        .msg_ready (msg_ready),
        .msg_valid (msg_valid),
        .msg_data  (msg_data)
    );

    // R1: the stream is quiet in the first cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !msg_valid);

endmodule

// File: tb/test_tt_msg_gen.sv
module test_tt_msg_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  din = 4'b0000;
    logic [7:0]  mask = 8'hFF;
    logic        mark = 1'b0;
    logic        rdy = 1'b1;
    logic        vld;
    logic [63:0] data;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tt_msg_gen i_tt_msg_gen (
        .clk       (clk),
        .rst       (rst),
        .tag_in    (din),
        .edge_en   (mask),
        .mark_req  (mark),
        .msg_ready (rdy),
        .msg_valid (vld),
        .msg_data  (data)
    );

    // cycle counter built from R5
    logic [47:0] bcnt;
    always @(posedge clk) begin
        if (rst) bcnt <= '0;
        else     bcnt <= bcnt + 1'b1;
    end

    // accepted-message monitor, sampled mid-cycle
    logic [63:0] got [256];
    int gcnt = 0;
    always @(negedge clk) begin
        if (!rst && vld && rdy) begin
            got[gcnt % 256] = data;
            gcnt = gcnt + 1;
        end
    end

    logic [63:0] expv [32];
    int ecnt;
    int base;

    // stimulus: mask[15:8], new input[7:4], hold[3:0] (0 = keep)
    localparam int NV = 8;
    localparam logic [15:0] VEC [NV] = '{
        16'hFF_1_0,   // R3 R4: ch0 rise
        16'hFF_0_3,   // R2: 3-cycle dip rejected
        16'hFF_F_0,   // R6: three rises together
        16'h55_6_0,   // R3: falls masked off
        16'hAA_9_0,   // R3: only falls enabled
        16'hFF_8_4,   // R2 R5: 4-cycle dip accepted, two events
        16'hFF_B_2,   // R2: 2-cycle pulse rejected
        16'h00_0_0    // R3: everything masked
    };

    function automatic logic [63:0] ev_msg(input int ch, input bit fall,
                                           input logic [3:0] st, input logic [47:0] t);
        return {4'h2, 3'(ch), fall, 4'h0, st, t};
    endfunction

    function automatic logic [63:0] mk_msg(input logic [3:0] st, input logic [47:0] t);
        return {8'h30, 4'h0, st, t};
    endfunction

    localparam logic [63:0] OVF_MSG = 64'h4000_0000_0000_0000;

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic start_seq();
        base = gcnt;
        ecnt = 0;
    endtask

    task automatic push(input logic [63:0] m);
        expv[ecnt] = m;
        ecnt = ecnt + 1;
    endtask

    task automatic push_edges(input logic [3:0] from, input logic [3:0] to,
                              input logic [7:0] en, input logic [47:0] t);
        for (int ch = 0; ch < 4; ch++) begin
            if (!from[ch] && to[ch] && en[2*ch])   push(ev_msg(ch, 1'b0, to, t));
            if (from[ch] && !to[ch] && en[2*ch+1]) push(ev_msg(ch, 1'b1, to, t));
        end
    endtask

    task automatic check_seq(input string tag);
        nchk++;
        if (gcnt - base != ecnt) begin
            nfail++;
            $display("FAIL %s message count actual %0d expected %0d", tag, gcnt - base, ecnt);
        end else begin
            for (int i = 0; i < ecnt; i++) begin
                nchk++;
                if (got[(base + i) % 256] !== expv[i]) begin
                    nfail++;
                    $display("FAIL %s message %0d actual %h expected %h",
                             tag, i, got[(base + i) % 256], expv[i]);
                end
            end
        end
    endtask

    initial begin
        logic [3:0]  cur;
        logic [47:0] v;

        // R1: reset state
        step(3);
        nchk++;
        if (vld !== 1'b0) begin
            nfail++;
            $display("FAIL R1 valid during reset actual %b expected 0", vld);
        end
        rst = 1'b0;
        nchk++;
        if (vld !== 1'b0) begin
            nfail++;
            $display("FAIL R1 valid after reset actual %b expected 0", vld);
        end
        // R1 R5 R7: marker in first cycle carries timestamp 0, levels 0
        start_seq();
        mark = 1'b1;
        step(1);
        mark = 1'b0;
        push(mk_msg(4'h0, 48'd0));
        step(6);
        check_seq("R1/R7 marker after reset");

        // vector table
        cur = 4'h0;
        for (int k = 0; k < NV; k++) begin
            logic [3:0] nv;
            logic [3:0] hold;
            mask = VEC[k][15:8];
            nv   = VEC[k][7:4];
            hold = VEC[k][3:0];
            start_seq();
            v = bcnt;
            din = nv;
            if (hold == 0) begin
                push_edges(cur, nv, mask, v + 48'd5);
                cur = nv;
            end else begin
                step(int'(hold));
                din = cur;
                if (hold >= 4) begin
                    push_edges(cur, nv, mask, v + 48'd5);
                    push_edges(nv, cur, mask, v + 48'(hold) + 48'd5);
                end
            end
            step(16);
            check_seq($sformatf("R2/R3/R4/R5/R6 vector %0d", k));
        end

        // R7: marker with every edge disabled, current levels 0000
        mask = 8'h00;
        start_seq();
        v = bcnt;
        mark = 1'b1;
        step(1);
        mark = 1'b0;
        push(mk_msg(cur, v));
        step(8);
        check_seq("R7 marker with mask clear");

        // R6 R7: events and marker captured together, marker last
        mask = 8'hFF;
        start_seq();
        v = bcnt;
        din = 4'b0101;
        step(5);
        mark = 1'b1;
        step(1);
        mark = 1'b0;
        push_edges(cur, 4'b0101, mask, v + 48'd5);
        push(mk_msg(4'b0101, v + 48'd5));
        cur = 4'b0101;
        step(12);
        check_seq("R6/R7 events then marker");

        // R8 R10: first message refused, overflow then the rest
        rdy = 1'b0;
        start_seq();
        v = bcnt;
        din = 4'b1010;
        step(14);
        nchk++;
        if (!(vld === 1'b1 && data === OVF_MSG)) begin
            nfail++;
            $display("FAIL R8 held overflow actual %b/%h expected 1/%h", vld, data, OVF_MSG);
        end
        rdy = 1'b1;
        push(OVF_MSG);
        push(ev_msg(1, 1'b0, 4'b1010, v + 48'd5));
        push(ev_msg(2, 1'b1, 4'b1010, v + 48'd5));
        push(ev_msg(3, 1'b0, 4'b1010, v + 48'd5));
        cur = 4'b1010;
        step(10);
        check_seq("R8/R10 refused message");

        // R9: second edge arrives while the first is held
        start_seq();
        v = bcnt;
        din = 4'b1011;
        step(1);
        din = 4'b1111;
        push(ev_msg(0, 1'b0, 4'b1011, v + 48'd5));
        push(OVF_MSG);
        cur = 4'b1111;
        step(14);
        check_seq("R9 discard while busy");

        // R9: filtered level still followed the discarded edge
        start_seq();
        v = bcnt;
        mark = 1'b1;
        step(1);
        mark = 1'b0;
        push(mk_msg(cur, v));
        step(8);
        check_seq("R9 level after discard");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule